// File: doc/BRIEF.md
# Charge-Pump Cycle Counter with Frame Timestamps

This block is the digital back end of a current-to-frequency integrator channel in an X-ray pixel. Each clock it registers the comparator flag that reports the analog integrator crossing its threshold. From that registered value it fires a one-clock pump pulse, and each pulse removes one fixed charge packet from the integrator. Within each frame it counts the pump pulses and records the frame tick at which the first pump and the last pump occurred. It also counts the hit strobes from the photon-counting channel over the same frame.

At the last tick of every frame, all results move into readout registers at once, and the working counters restart from zero in the same clock. Off-chip logic later forms the current as (pumps − 1) / (last − first) packets per clock. It then divides that by the hit count to get the mean photon energy. The frame length is a tick count taken from a configuration input while reset is held.

Top module: `ipump_frame_counter`

## Requirements
- R1: The comparator input passes through one register before use, and each pump pulse on `pumpOut` lasts exactly one clock. If `cmpIn` is high before edge e and the channel is not blanked, `pumpOut` is high in the clock that follows edge e+1.
- R2: A registered comparator value is ignored in the clock where the pump pulse is high and in the clock after it. A comparator held high therefore gives one pump every third clock.
- R3: The pump count of a frame includes a pump whose pulse falls on the frame's last tick. A pump whose pulse falls after that tick belongs to the next frame.
- R4: The first and last timestamps hold the frame tick (0 to length−1) of the clock in which the first and the last pump pulse of the frame was high.
- R5: Every clock in which `hitIn` is high adds one to the frame's hit count, including the frame's last tick.
- R6: At frame tick length−1, every readout output is loaded from that frame's totals, `rdStrobe` is high for one clock, and `rdValid` becomes 1 and stays 1. The working counters clear in the same clock. Readout values then stay unchanged until the next frame end.
- R7: `rdLowFlux` is 1 when a frame had fewer than two pumps. With no pumps both timestamps read 0. With one pump the first and last timestamps are equal.
- R8: The pump and hit counts saturate at all ones instead of wrapping. `rdPumpOvf` or `rdHitOvf` reports a frame in which a count would have passed all ones. Both flags are clear for a later frame that stays within range.
- R9: The frame length in ticks (at least 2) is captured from `frameLenCfg` while `rstN` is low. A frame then spans exactly that many clocks, starting with the first clock after reset.
- R10: While `rstN` is low, `pumpOut`, `rdStrobe`, `rdValid`, every count, every timestamp and every flag read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| frameLenCfg | input | TS_W | Frame length in ticks, sampled during reset |
| cmpIn | input | 1 | Integrator comparator threshold flag |
| hitIn | input | 1 | Photon-counter hit strobe, one per clock |
| pumpOut | output | 1 | One-clock charge-pump fire pulse |
| rdStrobe | output | 1 | One-clock pulse when new readout values are loaded |
| rdValid | output | 1 | At least one frame has completed |
| rdPumpCount | output | PUMP_W | Pump cycles in the last frame |
| rdFirstTs | output | TS_W | Tick of the first pump of the last frame |
| rdLastTs | output | TS_W | Tick of the last pump of the last frame |
| rdHitCount | output | HIT_W | Photon hits in the last frame |
| rdLowFlux | output | 1 | Fewer than two pumps in the last frame |
| rdPumpOvf | output | 1 | Pump count saturated in the last frame |
| rdHitOvf | output | 1 | Hit count saturated in the last frame |

## Verification
The bench holds the comparator high for several clocks. A design with no blanking, or with blanking one clock too short, would then fire back-to-back pumps and report too many cycles with the wrong last timestamp. Pumps and hits are placed on the final tick of a frame and on the first tick after it. A latch that used the registered counts instead of the updated ones would drop the final-tick event, and a late clear would move the spill-over pump into the wrong frame. Narrow counters are driven past all ones and followed by a quiet frame, which catches a counter that wraps and an overflow flag that never clears. Frames with zero pumps and with one pump check the low-flux flag and the timestamps that go with it.

// File: rtl/ipump_pkg.sv
package ipump_pkg;
  // strobes from control to datapath, one clock each
  typedef struct packed {
    logic pump;      // pump pulse is high this clock
    logic hit;       // photon hit this clock
    logic frameEnd;  // this clock is the last tick of the frame
  } ctrlStrobes_t;
endpackage

// File: rtl/ipump_ctrl.sv
module ipump_ctrl
  import ipump_pkg::*;
#(
  parameter int TS_W = 12
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [TS_W-1:0] frameLenCfg,
  input  logic            cmpIn,
  input  logic            hitIn,
  output logic            pumpOut,
  output logic [TS_W-1:0] tick,
  output ctrlStrobes_t    strobes
);
  logic [TS_W-1:0] lastTick;
  logic            cmpQ;
  logic            blankQ;
  logic            frameEnd;

  assign frameEnd = (tick == lastTick);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastTick <= frameLenCfg - TS_W'(1);
      tick     <= '0;
      cmpQ     <= 1'b0;
      pumpOut  <= 1'b0;
      blankQ   <= 1'b0;
    end else begin
      tick    <= frameEnd ? '0 : tick + TS_W'(1);
      cmpQ    <= cmpIn;
      pumpOut <= cmpQ & ~pumpOut & ~blankQ;
      blankQ  <= pumpOut;
    end
  end

  always_comb begin
    strobes.pump     = pumpOut;
    strobes.hit      = hitIn;
    strobes.frameEnd = frameEnd;
  end

  // R1: pulse width is one clock
  a_r1_pulse_width: assert property (@(posedge clk) disable iff (!rstN)
    pumpOut |=> !pumpOut);
  // R1: every pulse traces back to the comparator two edges earlier
  a_r1_sync_cause: assert property (@(posedge clk) disable iff (!rstN)
    pumpOut |-> $past(cmpIn, 2));
  // R2: no pulse in the two clocks after a pulse
  a_r2_blanking: assert property (@(posedge clk) disable iff (!rstN)
    pumpOut |=> !pumpOut ##1 !pumpOut);
  // R9: tick stays inside the frame
  a_r9_tick_bound: assert property (@(posedge clk) disable iff (!rstN)
    tick <= lastTick);
endmodule

// File: rtl/ipump_satcnt.sv
module ipump_satcnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cntNext,
  output logic         ovf,
  output logic         ovfNext
);
  logic full;
  assign full = &cnt;

  always_comb begin
    cntNext = cnt;
    ovfNext = ovf;
    if (inc) begin
      if (full) ovfNext = 1'b1;
      else      cntNext = cnt + W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || clr) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else begin
      cnt <= cntNext;
      ovf <= ovfNext;
    end
  end

  // R8: a full counter stays full until the frame clears it
  a_r8_saturate: assert property (@(posedge clk) disable iff (!rstN)
    (full && !clr) |=> full);
endmodule

// File: rtl/ipump_datapath.sv
module ipump_datapath
  import ipump_pkg::*;
#(
  parameter int TS_W   = 12,
  parameter int PUMP_W = 12,
  parameter int HIT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      s,
  input  logic [TS_W-1:0]   tick,
  output logic              rdStrobe,
  output logic              rdValid,
  output logic [PUMP_W-1:0] rdPumpCount,
  output logic [TS_W-1:0]   rdFirstTs,
  output logic [TS_W-1:0]   rdLastTs,
  output logic [HIT_W-1:0]  rdHitCount,
  output logic              rdLowFlux,
  output logic              rdPumpOvf,
  output logic              rdHitOvf
);
  localparam logic [PUMP_W-1:0] LOW_FLUX_LIMIT = PUMP_W'(2);

  logic [PUMP_W-1:0] pumpCnt, pumpNext;
  logic [HIT_W-1:0]  hitCnt, hitNext;
  logic              pumpOvfNext, hitOvfNext;
  logic              pumpOvfQ, hitOvfQ;
  logic [TS_W-1:0]   firstTs, lastTs, firstNext, lastNext;

  ipump_satcnt #(.W(PUMP_W)) pumpCnt_i (
    .clk(clk), .rstN(rstN), .inc(s.pump), .clr(s.frameEnd),
    .cnt(pumpCnt), .cntNext(pumpNext), .ovf(pumpOvfQ), .ovfNext(pumpOvfNext));

  ipump_satcnt #(.W(HIT_W)) hitCnt_i (
    .clk(clk), .rstN(rstN), .inc(s.hit), .clr(s.frameEnd),
    .cnt(hitCnt), .cntNext(hitNext), .ovf(hitOvfQ), .ovfNext(hitOvfNext));

  always_comb begin
    firstNext = firstTs;
    lastNext  = lastTs;
    if (s.pump) begin
      if (pumpCnt == '0) firstNext = tick;
      lastNext = tick;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      firstTs     <= '0;
      lastTs      <= '0;
      rdStrobe    <= 1'b0;
      rdValid     <= 1'b0;
      rdPumpCount <= '0;
      rdFirstTs   <= '0;
      rdLastTs    <= '0;
      rdHitCount  <= '0;
      rdLowFlux   <= 1'b0;
      rdPumpOvf   <= 1'b0;
      rdHitOvf    <= 1'b0;
    end else begin
      rdStrobe <= s.frameEnd;
      if (s.frameEnd) begin
        rdValid     <= 1'b1;
        rdPumpCount <= pumpNext;
        rdFirstTs   <= firstNext;
        rdLastTs    <= lastNext;
        rdHitCount  <= hitNext;
        rdLowFlux   <= (pumpNext < LOW_FLUX_LIMIT);
        rdPumpOvf   <= pumpOvfNext;
        rdHitOvf    <= hitOvfNext;
        firstTs     <= '0;
        lastTs      <= '0;
      end else begin
        firstTs <= firstNext;
        lastTs  <= lastNext;
      end
    end
  end

  // R6: the frame end clears the working counts and raises the strobe
  a_r6_clear: assert property (@(posedge clk) disable iff (!rstN)
    s.frameEnd |=> (rdStrobe && pumpCnt == '0 && hitCnt == '0 && rdValid));
  // R6: readout stays put between frame ends
  a_r6_hold: assert property (@(posedge clk) disable iff (!rstN)
    !s.frameEnd |=> ($stable(rdPumpCount) && $stable(rdLastTs) && $stable(rdHitCount)));
  // R7: an empty frame reports zero timestamps
  a_r7_empty_ts: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && rdPumpCount == '0) |-> (rdFirstTs == '0 && rdLastTs == '0));
  // R7: a single pump gives equal timestamps
  a_r7_single_ts: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && rdPumpCount == PUMP_W'(1)) |-> (rdFirstTs == rdLastTs));
endmodule

// File: rtl/ipump_frame_counter.sv
module ipump_frame_counter
  import ipump_pkg::*;
#(
  parameter int TS_W   = 12,
  parameter int PUMP_W = 12,
  parameter int HIT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TS_W-1:0]   frameLenCfg,
  input  logic              cmpIn,
  input  logic              hitIn,
  output logic              pumpOut,
  output logic              rdStrobe,
  output logic              rdValid,
  output logic [PUMP_W-1:0] rdPumpCount,
  output logic [TS_W-1:0]   rdFirstTs,
  output logic [TS_W-1:0]   rdLastTs,
  output logic [HIT_W-1:0]  rdHitCount,
  output logic              rdLowFlux,
  output logic              rdPumpOvf,
  output logic              rdHitOvf
);
  ctrlStrobes_t    strobes;
  logic [TS_W-1:0] tick;

  ipump_ctrl #(.TS_W(TS_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .frameLenCfg(frameLenCfg),
    .cmpIn(cmpIn), .hitIn(hitIn),
    .pumpOut(pumpOut), .tick(tick), .strobes(strobes));

  ipump_datapath #(.TS_W(TS_W), .PUMP_W(PUMP_W), .HIT_W(HIT_W)) dp_i (
    .clk(clk), .rstN(rstN), .s(strobes), .tick(tick),
    .rdStrobe(rdStrobe), .rdValid(rdValid),
    .rdPumpCount(rdPumpCount), .rdFirstTs(rdFirstTs), .rdLastTs(rdLastTs),
    .rdHitCount(rdHitCount), .rdLowFlux(rdLowFlux),
    .rdPumpOvf(rdPumpOvf), .rdHitOvf(rdHitOvf));
endmodule

// File: tb/ipump_frame_counter_tb_top.sv
module ipump_frame_counter_tb_top;
  localparam int TS_W = 12;
  localparam int PW   = 4;
  localparam int HW   = 4;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [TS_W-1:0] frameLenCfg = '0;
  logic            cmpIn = 1'b0;
  logic            hitIn = 1'b0;
  logic            pumpOut, rdStrobe, rdValid, rdLowFlux, rdPumpOvf, rdHitOvf;
  logic [PW-1:0]   rdPumpCount;
  logic [TS_W-1:0] rdFirstTs, rdLastTs;
  logic [HW-1:0]   rdHitCount;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  ipump_frame_counter #(.TS_W(TS_W), .PUMP_W(PW), .HIT_W(HW)) dut_i (
    .clk(clk), .rstN(rstN), .frameLenCfg(frameLenCfg),
    .cmpIn(cmpIn), .hitIn(hitIn), .pumpOut(pumpOut),
    .rdStrobe(rdStrobe), .rdValid(rdValid),
    .rdPumpCount(rdPumpCount), .rdFirstTs(rdFirstTs), .rdLastTs(rdLastTs),
    .rdHitCount(rdHitCount), .rdLowFlux(rdLowFlux),
    .rdPumpOvf(rdPumpOvf), .rdHitOvf(rdHitOvf));

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  // hold reset for three edges; returns at a falling edge before frame tick 0
  task automatic doReset(input int len);
    rstN = 1'b0; frameLenCfg = TS_W'(len); cmpIn = 1'b0; hitIn = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  // present inputs for one frame tick
  task automatic step(input bit c, input bit h);
    cmpIn = c; hitIn = h;
    @(negedge clk);
  endtask

  task automatic checkFrame(input string req, input int cnt, input int fts, input int lts,
                            input int hits, input int low, input int pov, input int hov);
    chk(req, "rdStrobe", rdStrobe, 1);
    chk(req, "rdValid", rdValid, 1);
    chk(req, "rdPumpCount", rdPumpCount, cnt);
    chk(req, "rdFirstTs", rdFirstTs, fts);
    chk(req, "rdLastTs", rdLastTs, lts);
    chk(req, "rdHitCount", rdHitCount, hits);
    chk(req, "rdLowFlux", rdLowFlux, low);
    chk(req, "rdPumpOvf", rdPumpOvf, pov);
    chk(req, "rdHitOvf", rdHitOvf, hov);
  endtask

  task automatic t_reset();
    rstN = 1'b0; cmpIn = 1'b1; hitIn = 1'b1; frameLenCfg = TS_W'(20);
    repeat (3) @(negedge clk);
    // R10: everything idle while reset holds
    chk("R10", "pumpOut", pumpOut, 0);
    chk("R10", "rdStrobe", rdStrobe, 0);
    chk("R10", "rdValid", rdValid, 0);
    chk("R10", "rdPumpCount", rdPumpCount, 0);
    chk("R10", "rdHitCount", rdHitCount, 0);
    chk("R10", "rdLastTs", rdLastTs, 0);
    chk("R10", "flags", {rdLowFlux, rdPumpOvf, rdHitOvf}, 0);
  endtask

  task automatic t_two_pumps();
    doReset(100);
    for (int i = 0; i < 100; i++) begin
      step(i == 10 || i == 60, (i % 20) == 3);
      if (i == 11) chk("R1", "pumpOut two clocks after cmpIn", pumpOut, 1);
      if (i == 12) chk("R1", "pumpOut width", pumpOut, 0);
      if (i == 98) chk("R9", "rdStrobe before last tick", rdStrobe, 0);
    end
    // R3 R4 R5 R6: two pumps at ticks 12 and 62, five hits
    checkFrame("R4", 2, 12, 62, 5, 0, 0, 0);
    step(1'b0, 1'b0);
    chk("R6", "rdStrobe one clock", rdStrobe, 0);
    chk("R6", "rdValid sticky", rdValid, 1);
    chk("R6", "rdPumpCount held", rdPumpCount, 2);
  endtask

  task automatic t_blank();
    doReset(40);
    for (int i = 0; i < 40; i++) begin
      step(i >= 5 && i <= 10, 1'b0);
      if (i == 6) chk("R2", "first pulse", pumpOut, 1);
      if (i == 7) chk("R2", "ignored in pulse clock", pumpOut, 0);
      if (i == 8) chk("R2", "ignored clock after pulse", pumpOut, 0);
      if (i == 9) chk("R2", "second pulse", pumpOut, 1);
    end
    checkFrame("R2", 2, 7, 10, 0, 0, 0, 0);
  endtask

  task automatic t_low_flux();
    doReset(30);
    for (int i = 0; i < 30; i++) step(i == 4, 1'b0);
    checkFrame("R7", 1, 6, 6, 0, 1, 0, 0);
    for (int i = 0; i < 30; i++) step(1'b0, 1'b0);
    checkFrame("R7", 0, 0, 0, 0, 1, 0, 0);
  endtask

  task automatic t_saturate();
    doReset(80);
    // comparator high for ticks 0..69 gives 24 pumps at ticks 2..71; 20 hits
    for (int i = 0; i < 80; i++) step(i < 70, i < 20);
    checkFrame("R8", 15, 2, 71, 15, 0, 1, 1);
    for (int i = 0; i < 80; i++) step(1'b0, i < 3);
    checkFrame("R8", 0, 0, 0, 3, 1, 0, 0);
  endtask

  task automatic t_boundary();
    // pump pulse and hit on the last tick stay in the frame
    doReset(50);
    for (int i = 0; i < 50; i++) begin
      step(i == 47, i == 49);
      if (i == 48) chk("R9", "rdStrobe before last tick", rdStrobe, 0);
    end
    checkFrame("R3", 1, 49, 49, 1, 1, 0, 0);
    // pump pulse one tick late lands at tick 0 of the next frame
    doReset(50);
    for (int i = 0; i < 50; i++) step(i == 48, 1'b0);
    checkFrame("R3", 0, 0, 0, 0, 1, 0, 0);
    for (int i = 0; i < 50; i++) step(1'b0, 1'b0);
    checkFrame("R3", 1, 0, 0, 0, 1, 0, 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_two_pumps();
    t_blank();
    t_low_flux();
    t_saturate();
    t_boundary();
    done = 1'b1;
    summary();
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      summary();
    end
  end
endmodule